// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block is a purely combinational routing matrix. It places the signals of the enabled on-chip peripherals onto the general-purpose pins of four 8-bit ports, 32 pins in total. Signals are not tied to fixed pins. The block walks a fixed priority list of peripheral signals and gives each requested signal the next free pin, counting up from pin 0. A pin is not free when the external memory interface reserves it for its strobes, or when it is a port-1 pin configured as analog. A pin that receives no signal behaves as plain general-purpose I/O and drives the value from its port data latch.

Inputs route in the other direction. Each peripheral input reads the pin its signal was placed on. A signal that found no pin reads a fixed idle level. While an off-chip memory access is in progress, the external memory interface takes over the pins it owns, whatever the crossbar decided. On a read, it releases the data-bus pins so that the external device can drive them.

Top module: `prio_xbar`

## Requirements
- R1: With `grp_en` = 0, `pca_cnt` = 0 and `emif_low` = 0, every pin reports select code 31 (general I/O), drives `port_latch` with `pin_oe` = 1, and every `periph_in` bit holds its idle level. The idle level is 1 for the active-low inputs (signal ids 5, 19 and 21) and 0 for all others.
- R2: Signal ids, in priority order, are:
  - 0 UART0 TX and 1 UART0 RX.
  - 2 SCK, 3 MISO, 4 MOSI and 5 slave select.
  - 6 SDA and 7 SCL.
  - 8 UART1 TX and 9 UART1 RX.
  - 10 to 14 for PCA outputs 0 to 4.
  - 15 ECI, 16 CP0, 17 CP1, 18 T0, 19 INT0 (active low), 20 T1, 21 INT1 (active low), 22 T2, 23 T2EX, 24 T4, 25 T4EX, 26 SYSCLK out and 27 CNVSTR.
  
  `grp_en` bits 0 to 16 enable, in this order: UART0, SPI, SMBus, UART1, ECI, CP0, CP1, T0, INT0, T1, INT1, T2, T2EX, T4, T4EX, SYSCLK and CNVSTR. A disabled group gets no pin.
- R3: Requested signals are placed in ascending id order onto free pins in ascending pin order, starting from pin 0. `pin_sel` reports the id placed on each pin.
- R4: `pca_cnt` = n routes PCA outputs 0 to min(n,5)-1. Values 6 and 7 act as 5.
- R5: When `emif_low` = 1, pins 7 and 6 are reserved and report select code 28. With `emif_mux` = 1, pin 5 is reserved as well. Reserved pins receive no signal and, unless overridden, drive `port_latch` with `pin_oe` = 1.
- R6: Pin 8+i is skipped (select code 31, driven from the latch) when `p1_digital[i]` = 0.
- R7: Signals that do not fit on the remaining free pins are unrouted. Their `periph_in` bit reads the idle level from R1.
- R8: A pin carrying signal s drives `periph_out[s]` with enable `periph_oe[s]`, and `periph_in[s]` follows that pin's `pin_in`.
- R9: When `emif_low`, `emif_active` and `emif_drive[p]` are all 1, pin p drives `emif_val[p]` with `pin_oe` = 1. The exception is when `emif_rd` and `emif_dbus[p]` are both 1, in which case `pin_oe` = 0. `pin_sel` is unchanged by the override.
- R10: With `emif_low` = 0, `emif_active` and the other interface inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_en | input | 17 | Per-group enables, priority order |
| pca_cnt | input | 3 | Number of PCA outputs to route |
| emif_low | input | 1 | Memory interface lives on the low ports |
| emif_mux | input | 1 | Memory interface uses multiplexed address/data |
| p1_digital | input | 8 | Port-1 digital mask, 0 = analog pin |
| port_latch | input | 32 | Port data latch values |
| pin_in | input | 32 | Sampled pad levels |
| periph_out | input | 28 | Output value per signal id |
| periph_oe | input | 28 | Output enable per signal id |
| emif_active | input | 1 | Off-chip access execution phase |
| emif_rd | input | 1 | Current off-chip access is a read |
| emif_drive | input | 32 | Pins owned by the memory interface |
| emif_val | input | 32 | Memory interface pin values |
| emif_dbus | input | 32 | Pins forming the data bus |
| pin_sel | output | 32x5 | Select code per pin: id, 28 reserved, 31 general I/O |
| pin_out | output | 32 | Pad output value |
| pin_oe | output | 32 | Pad output enable |
| periph_in | output | 28 | Input value per signal id |

## Verification
The hardest state to reach is overflow. It needs many groups enabled together with a shrunken free-pin list from the reserved strobe pins and analog port-1 pins, so that the tail of the priority list falls off the end. The stimulus forces this with a directed vector that enables everything while masking all of port 1 and reserving three pins. It then runs random vectors with dense enables and random analog masks. A queue-based reference allocator walks the free-pin list, and every pin code, drive value and input route is compared against it.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
   localparam int NSIG      = 28;
   localparam int NGRP      = 17;
   localparam int PCA_MAX   = 5;
   localparam int PCA_BASE  = 10;
   localparam int PCA_CNT_W = 3;
   localparam int SEL_W     = 5;
   localparam logic [SEL_W-1:0] SEL_RSV  = 5'd28;
   localparam logic [SEL_W-1:0] SEL_GPIO = 5'd31;
   // active-low inputs rest high when unrouted
   localparam logic [NSIG-1:0] IDLE_HIGH = NSIG'((1 << 5) | (1 << 19) | (1 << 21));

   // group that owns a non-PCA signal id
   function automatic int sig_grp(input int s);
      if (s < 2)       return 0;
      else if (s < 6)  return 1;
      else if (s < 8)  return 2;
      else if (s < 10) return 3;
      else             return s - 11;
   endfunction
endpackage

// File: rtl/prio_xbar_req.sv
module prio_xbar_req
   import prio_xbar_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [NGRP-1:0]            grp_en,
   input  logic [PCA_CNT_W-1:0]       pca_cnt,
   output logic [NSIG-1:0]            sig_req,
   output logic [NSIG-1:0][CNT_W-1:0] slot
);
   for (genvar s = 0; s < NSIG; s++) begin : g_sig
      if (s >= PCA_BASE && s < PCA_BASE + PCA_MAX) begin : g_pca
         assign sig_req[s] = (pca_cnt > PCA_CNT_W'(s - PCA_BASE));
      end else begin : g_grp
         assign sig_req[s] = grp_en[sig_grp(s)];
      end
   end

   // running count of requests ahead of each signal
   always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int s = 0; s < NSIG; s++) begin
         slot[s] = acc;
         acc     = acc + CNT_W'(sig_req[s]);
      end
   end
endmodule

// File: rtl/prio_xbar_freemap.sv
module prio_xbar_freemap #(
   parameter int NPIN   = 32,
   parameter int PORT_W = 8,
   parameter int CNT_W  = 6
) (
   input  logic                       emif_low,
   input  logic                       emif_mux,
   input  logic [PORT_W-1:0]          p1_digital,
   output logic [NPIN-1:0]            pin_rsv,
   output logic [NPIN-1:0]            pin_free,
   output logic [NPIN-1:0][CNT_W-1:0] rank
);
   localparam int PIN_WR  = 7;
   localparam int PIN_RD  = 6;
   localparam int PIN_ALE = 5;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic analog;
      if (p == PIN_WR || p == PIN_RD) begin : g_strobe
         assign pin_rsv[p] = emif_low;
      end else if (p == PIN_ALE) begin : g_ale
         assign pin_rsv[p] = emif_low & emif_mux;
      end else begin : g_plain
         assign pin_rsv[p] = 1'b0;
      end
      if (p >= PORT_W && p < 2 * PORT_W) begin : g_p1
         assign analog = ~p1_digital[p - PORT_W];
      end else begin : g_dig
         assign analog = 1'b0;
      end
      assign pin_free[p] = ~pin_rsv[p] & ~analog;
   end

   always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int p = 0; p < NPIN; p++) begin
         rank[p] = acc;
         acc     = acc + CNT_W'(pin_free[p]);
      end
   end
endmodule

// File: rtl/prio_xbar_route.sv
module prio_xbar_route
   import prio_xbar_pkg::*;
#(
   parameter int NPIN  = 32,
   parameter int CNT_W = 6,
   parameter int PIN_W = 5
) (
   input  logic [NPIN-1:0]            pin_rsv,
   input  logic [NPIN-1:0]            pin_free,
   input  logic [NPIN-1:0][CNT_W-1:0] rank,
   input  logic [NSIG-1:0]            sig_req,
   input  logic [NSIG-1:0][CNT_W-1:0] slot,
   output logic [NPIN-1:0][SEL_W-1:0] pin_sel,
   output logic [NSIG-1:0]            sig_hit,
   output logic [NSIG-1:0][PIN_W-1:0] sig_pin
);
   // pin side: which slot matches this pin's free rank
   always_comb begin
      for (int p = 0; p < NPIN; p++) begin
         pin_sel[p] = pin_rsv[p] ? SEL_RSV : SEL_GPIO;
         for (int s = 0; s < NSIG; s++) begin
            if (pin_free[p] && sig_req[s] && slot[s] == rank[p])
               pin_sel[p] = SEL_W'(s);
         end
      end
   end

   // signal side: which pin the slot landed on, if any
   always_comb begin
      for (int s = 0; s < NSIG; s++) begin
         sig_hit[s] = 1'b0;
         sig_pin[s] = '0;
         for (int p = 0; p < NPIN; p++) begin
            if (pin_free[p] && sig_req[s] && rank[p] == slot[s]) begin
               sig_hit[s] = 1'b1;
               sig_pin[s] = PIN_W'(p);
            end
         end
      end
   end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
   import prio_xbar_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int PORT_W = 8
) (
   input  logic [NGRP-1:0]                    grp_en,
   input  logic [PCA_CNT_W-1:0]               pca_cnt,
   input  logic                               emif_low,
   input  logic                               emif_mux,
   input  logic [PORT_W-1:0]                  p1_digital,
   input  logic [NPORT*PORT_W-1:0]            port_latch,
   input  logic [NPORT*PORT_W-1:0]            pin_in,
   input  logic [NSIG-1:0]                    periph_out,
   input  logic [NSIG-1:0]                    periph_oe,
   input  logic                               emif_active,
   input  logic                               emif_rd,
   input  logic [NPORT*PORT_W-1:0]            emif_drive,
   input  logic [NPORT*PORT_W-1:0]            emif_val,
   input  logic [NPORT*PORT_W-1:0]            emif_dbus,
   output logic [NPORT*PORT_W-1:0][SEL_W-1:0] pin_sel,
   output logic [NPORT*PORT_W-1:0]            pin_out,
   output logic [NPORT*PORT_W-1:0]            pin_oe,
   output logic [NSIG-1:0]                    periph_in
);
   localparam int NPIN  = NPORT * PORT_W;
   localparam int CNT_W = $clog2((NPIN > NSIG ? NPIN : NSIG) + 1);
   localparam int PIN_W = $clog2(NPIN);

   if (PORT_W < 8) begin : g_bad_width
      $error("prio_xbar: PORT_W must be at least 8");
   end
   if (NPORT < 2) begin : g_bad_ports
      $error("prio_xbar: at least two ports are required");
   end
   if (NPIN > 32) begin : g_bad_pins
      $error("prio_xbar: select codes cover at most 32 pins");
   end

   logic [NSIG-1:0]            sig_req;
   logic [NSIG-1:0][CNT_W-1:0] slot;
   logic [NPIN-1:0]            pin_rsv;
   logic [NPIN-1:0]            pin_free;
   logic [NPIN-1:0][CNT_W-1:0] rank;
   logic [NSIG-1:0]            sig_hit;
   logic [NSIG-1:0][PIN_W-1:0] sig_pin;

   prio_xbar_req #(.CNT_W(CNT_W)) u_req (
      .grp_en (grp_en),
      .pca_cnt(pca_cnt),
      .sig_req(sig_req),
      .slot   (slot)
   );

   prio_xbar_freemap #(.NPIN(NPIN), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_free (
      .emif_low  (emif_low),
      .emif_mux  (emif_mux),
      .p1_digital(p1_digital),
      .pin_rsv   (pin_rsv),
      .pin_free  (pin_free),
      .rank      (rank)
   );

   prio_xbar_route #(.NPIN(NPIN), .CNT_W(CNT_W), .PIN_W(PIN_W)) u_route (
      .pin_rsv (pin_rsv),
      .pin_free(pin_free),
      .rank    (rank),
      .sig_req (sig_req),
      .slot    (slot),
      .pin_sel (pin_sel),
      .sig_hit (sig_hit),
      .sig_pin (sig_pin)
   );

   // pad drive: memory override, then peripheral, then latch
   for (genvar p = 0; p < NPIN; p++) begin : g_drv
      logic ovr;
      assign ovr = emif_low & emif_active & emif_drive[p];
      always_comb begin
         if (ovr) begin
            pin_out[p] = emif_val[p];
            pin_oe[p]  = ~(emif_rd & emif_dbus[p]);
         end else if (pin_sel[p] < SEL_W'(NSIG)) begin
            pin_out[p] = periph_out[pin_sel[p]];
            pin_oe[p]  = periph_oe[pin_sel[p]];
         end else begin
            pin_out[p] = port_latch[p];
            pin_oe[p]  = 1'b1;
         end
      end
   end

   // input return path
   for (genvar s = 0; s < NSIG; s++) begin : g_in
      assign periph_in[s] = sig_hit[s] ? pin_in[sig_pin[s]] : IDLE_HIGH[s];
   end
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk
   import prio_xbar_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int PORT_W = 8
) (
   input logic                       emif_low,
   input logic                       emif_mux,
   input logic [PORT_W-1:0]          p1_digital,
   input logic                       emif_active,
   input logic                       emif_rd,
   input logic [NPIN-1:0]            emif_drive,
   input logic [NPIN-1:0]            emif_dbus,
   input logic [NPIN-1:0]            pin_in,
   input logic [NPIN-1:0][SEL_W-1:0] pin_sel,
   input logic [NPIN-1:0]            pin_oe,
   input logic [NSIG-1:0]            periph_in
);
   always_comb begin
      // R5
      strobe_rsv_chk: assert (!emif_low || (pin_sel[7] == SEL_RSV && pin_sel[6] == SEL_RSV));
      // R5
      ale_rsv_chk: assert (!(emif_low && emif_mux) || pin_sel[5] == SEL_RSV);
      for (int i = 0; i < PORT_W; i++) begin
         // R6
         analog_skip_chk: assert (p1_digital[i] || pin_sel[PORT_W + i] == SEL_GPIO);
      end
      for (int s = 0; s < NSIG; s++) begin
         int cnt;
         cnt = 0;
         for (int p = 0; p < NPIN; p++)
            if (pin_sel[p] == SEL_W'(s)) cnt++;
         // R3
         unique_sig_chk: assert (cnt <= 1);
      end
      for (int p = 0; p < NPIN; p++) begin
         if (pin_sel[p] < SEL_W'(NSIG)) begin
            // R8
            route_in_chk: assert (periph_in[pin_sel[p]] == pin_in[p]);
         end
         // R9
         rd_float_chk: assert (!(emif_low && emif_active && emif_rd && emif_drive[p] && emif_dbus[p]) || !pin_oe[p]);
      end
   end
endmodule

bind prio_xbar prio_xbar_chk #(.NPIN(NPORT * PORT_W), .PORT_W(PORT_W)) u_chk (
   .emif_low   (emif_low),
   .emif_mux   (emif_mux),
   .p1_digital (p1_digital),
   .emif_active(emif_active),
   .emif_rd    (emif_rd),
   .emif_drive (emif_drive),
   .emif_dbus  (emif_dbus),
   .pin_in     (pin_in),
   .pin_sel    (pin_sel),
   .pin_oe     (pin_oe),
   .periph_in  (periph_in)
);

// File: tb/prio_xbar_test.sv
`timescale 1ns/1ps
module prio_xbar_test;
   localparam int NP = 32;
   localparam int NS = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [16:0]        grp_en;
   logic [2:0]         pca_cnt;
   logic               emif_low, emif_mux, emif_active, emif_rd;
   logic [7:0]         p1_digital;
   logic [NP-1:0]      port_latch, pin_in, emif_drive, emif_val, emif_dbus;
   logic [NS-1:0]      periph_out, periph_oe;
   logic [NP-1:0][4:0] pin_sel;
   logic [NP-1:0]      pin_out, pin_oe;
   logic [NS-1:0]      periph_in;

   prio_xbar uut (
      .grp_en(grp_en), .pca_cnt(pca_cnt), .emif_low(emif_low), .emif_mux(emif_mux),
      .p1_digital(p1_digital), .port_latch(port_latch), .pin_in(pin_in),
      .periph_out(periph_out), .periph_oe(periph_oe), .emif_active(emif_active),
      .emif_rd(emif_rd), .emif_drive(emif_drive), .emif_val(emif_val),
      .emif_dbus(emif_dbus), .pin_sel(pin_sel), .pin_out(pin_out),
      .pin_oe(pin_oe), .periph_in(periph_in)
   );

   typedef struct {
      string              tag;
      logic [NP-1:0][4:0] sel;
      logic [NP-1:0]      out;
      logic [NP-1:0]      oe;
      logic [NS-1:0]      pin;
   } exp_t;

   exp_t q[$];
   int   applied = 0;
   int   fails = 0;
   bit   done = 0;

   // request per signal id, from the R2/R4 encodings
   function automatic bit want(int s);
      if (s < 2)  return grp_en[0];
      if (s < 6)  return grp_en[1];
      if (s < 8)  return grp_en[2];
      if (s < 10) return grp_en[3];
      if (s < 15) return (s - 10) < ((pca_cnt > 5) ? 5 : int'(pca_cnt));
      return grp_en[s - 11];
   endfunction

   function automatic exp_t model(string tag);
      exp_t e;
      int   freel[$];
      int   where[NS];
      int   k;
      logic [NS-1:0] idle;
      idle = '0;
      idle[5] = 1'b1; idle[19] = 1'b1; idle[21] = 1'b1;
      e.tag = tag;
      for (int p = 0; p < NP; p++) begin
         bit rsv, ana;
         rsv = emif_low && (p == 7 || p == 6 || (emif_mux && p == 5));
         ana = (p >= 8 && p < 16) && !p1_digital[p - 8];
         e.sel[p] = rsv ? 5'd28 : 5'd31;
         if (!rsv && !ana) freel.push_back(p);
      end
      k = 0;
      for (int s = 0; s < NS; s++) begin
         where[s] = -1;
         if (want(s)) begin
            if (k < freel.size()) begin
               where[s] = freel[k];
               e.sel[freel[k]] = 5'(s);
            end
            k++;
         end
      end
      for (int p = 0; p < NP; p++) begin
         if (emif_low && emif_active && emif_drive[p]) begin
            e.out[p] = emif_val[p];
            e.oe[p]  = !(emif_rd && emif_dbus[p]);
         end else if (e.sel[p] < 5'd28) begin
            e.out[p] = periph_out[e.sel[p]];
            e.oe[p]  = periph_oe[e.sel[p]];
         end else begin
            e.out[p] = port_latch[p];
            e.oe[p]  = 1'b1;
         end
      end
      for (int s = 0; s < NS; s++)
         e.pin[s] = (where[s] >= 0) ? pin_in[where[s]] : idle[s];
      return e;
   endfunction

   task automatic push(string tag);
      q.push_back(model(tag));
   endtask

   task automatic rand_data();
      port_latch = $urandom; pin_in = $urandom; emif_val = $urandom;
      emif_drive = $urandom; emif_dbus = $urandom;
      periph_out = NS'($urandom); periph_oe = NS'($urandom);
   endtask

   task automatic quiet();
      grp_en = '0; pca_cnt = '0; emif_low = 0; emif_mux = 0; emif_active = 0;
      emif_rd = 0; p1_digital = 8'hFF;
   endtask

   // monitor: compare one queued item per cycle away from the driving edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         bit   bad;
         e = q.pop_front();
         bad = 0;
         applied++;
         if (pin_sel !== e.sel) begin
            $display("FAIL %s pin_sel got %h exp %h", e.tag, pin_sel, e.sel); bad = 1;
         end
         if (pin_out !== e.out) begin
            $display("FAIL %s pin_out got %h exp %h", e.tag, pin_out, e.out); bad = 1;
         end
         if (pin_oe !== e.oe) begin
            $display("FAIL %s pin_oe got %h exp %h", e.tag, pin_oe, e.oe); bad = 1;
         end
         if (periph_in !== e.pin) begin
            $display("FAIL %s periph_in got %h exp %h", e.tag, periph_in, e.pin); bad = 1;
         end
         if (bad) fails++;
      end
   end

   initial begin
      quiet();
      rand_data();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1: nothing enabled
      @(posedge clk); quiet(); rand_data(); push("R1 idle");
      // R10: interface activity ignored without emif_low
      @(posedge clk); quiet(); rand_data(); emif_active = 1; emif_rd = 1;
      emif_drive = '1; emif_dbus = '1; push("R10 no low-port interface");
      // R3: UART0 only, pins 0 and 1
      @(posedge clk); quiet(); rand_data(); grp_en = 17'h1; push("R3 uart0 only");
      // R2: low-priority group alone lands on pin 0
      @(posedge clk); quiet(); rand_data(); grp_en = 17'h10000; push("R2 cnvstr alone");
      // R4: count beyond five
      @(posedge clk); quiet(); rand_data(); pca_cnt = 3'd7; grp_en = 17'h10; push("R4 pca 7");
      @(posedge clk); quiet(); rand_data(); pca_cnt = 3'd3; push("R4 pca 3");
      // R5: multiplexed and non-multiplexed reservation
      @(posedge clk); quiet(); rand_data(); emif_low = 1; emif_mux = 1; grp_en = 17'h0F; push("R5 mux");
      @(posedge clk); quiet(); rand_data(); emif_low = 1; grp_en = 17'h0F; push("R5 nonmux");
      // R6: all of port 1 analog
      @(posedge clk); quiet(); rand_data(); p1_digital = 8'h00; grp_en = 17'h0F; pca_cnt = 5; push("R6 analog");
      // R7: overflow with everything enabled
      @(posedge clk); quiet(); rand_data(); grp_en = '1; pca_cnt = 5; emif_low = 1; emif_mux = 1;
      p1_digital = 8'h00; push("R7 overflow");
      // R8: routed drive and return
      @(posedge clk); quiet(); rand_data(); grp_en = 17'h1FF; push("R8 routed");
      // R9: read and write overrides
      @(posedge clk); quiet(); rand_data(); grp_en = '1; emif_low = 1; emif_active = 1; emif_rd = 1;
      push("R9 read");
      @(posedge clk); quiet(); rand_data(); grp_en = '1; emif_low = 1; emif_active = 1; push("R9 write");

      // R3: random mixes against the reference allocator
      for (int i = 0; i < 600; i++) begin
         @(posedge clk);
         rand_data();
         grp_en      = 17'($urandom);
         pca_cnt     = 3'($urandom);
         emif_low    = 1'($urandom);
         emif_mux    = 1'($urandom);
         emif_active = 1'($urandom);
         emif_rd     = 1'($urandom);
         p1_digital  = (i % 3 == 0) ? 8'hFF : 8'($urandom);
         push("R3 random");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired got hang exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
         $finish;
      end
   end
endmodule